// File: doc/BRIEF.md
# Exclusive-Access Reservation Monitor

This block sits beside a memory that two bus requesters share and settles the exclusive-okay answer for every access they make. Each requester owns one reservation slot, picked by its port position: port 0 is the instruction fetch port and port 1 is the data port. An exclusive read records an 8-byte granule in the requester's slot. A later exclusive write by the same requester succeeds only if that reservation is still intact. A successful exclusive write or a plain write from any requester takes away the reservations that other requesters hold on the same granule.

The memory array and the bus data path stay outside the block. The memory controller reads `wr_suppress` to drop a failed exclusive write, and the bus response logic forwards `excl_okay` as the exclusive-okay response. A single configuration register at offset 0x018 turns the monitor on and off. While the monitor is off, every access reports exclusive-okay high and no reservation changes.

Top module: `excl_mon_top`

## Requirements
- R1: After reset the monitor is disabled and both slots are invalid. Once it is enabled, an exclusive write with no earlier exclusive read fails.
- R2: A configuration write to offset 0x018 sets the enable to 1 when the data is nonzero and to 0 when it is zero. A configuration write to any other offset does not change the enable.
- R3: While the monitor is disabled, a valid access without bus error gets `excl_okay` = 1 and `wr_suppress` = 0, and no slot changes.
- R4: On a port with no valid access, `excl_okay` equals the inverse of the enable.
- R5: When the monitor is enabled, an exclusive read (write=0, excl=1) gets `excl_okay` = 1. It marks the requester's own slot valid and stores the address with bits [2:0] cleared.
- R6: An exclusive write (write=1, excl=1) succeeds only when the requester's own slot is valid and holds the same 8-byte granule. Address bits [2:0] are ignored in this comparison.
- R7: An exclusive write always leaves the requester's own slot invalid, whether it succeeds or fails.
- R8: A successful exclusive write invalidates every other slot that holds the same granule and leaves other granules untouched.
- R9: A plain write gets `excl_okay` = 0 and invalidates other slots that hold its granule, but not the writer's own slot. A plain read gets `excl_okay` = 0 and changes nothing.
- R10: `wr_suppress` is 1 exactly for an exclusive write that fails while the monitor is enabled.
- R11: A bus error on a valid access forces `excl_okay` to 0. The reservation update still takes place.
- R12: When both ports access in the same cycle, port 1 is evaluated against the slot state that port 0's access has already produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 12 | Configuration offset from the I/O base |
| cfg_wr_data | input | 32 | Configuration write data |
| acc_valid | input | 2 | Per-port access valid |
| acc_addr | input | 64 | Per-port byte address, port p at bits [32p+31:32p] |
| acc_write | input | 2 | Per-port write flag |
| acc_excl | input | 2 | Per-port exclusive flag |
| acc_err | input | 2 | Per-port bus error of the current access |
| excl_okay | output | 2 | Per-port exclusive-okay response |
| wr_suppress | output | 2 | Per-port memory write block for failed exclusive writes |

## Verification
Directed sequences first exercise each access kind on its own. They pair exclusive reads and writes on the same granule, on a neighbouring byte of that granule and on a different granule, which tells a full-address compare apart from a granule compare. Cross-port runs separate matching from non-matching invalidation and plain writes from successful exclusive writes. Same-cycle pairs show whether port 1 sees port 0's update. A long pseudo-random sweep then drives both ports every cycle over a pool of four addresses in two granules, with scattered bus errors and enable changes, and compares every output against an arithmetic reservation model kept in the bench.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PLAIN_RD,
    ACC_PLAIN_WR,
    ACC_EXCL_RD,
    ACC_EXCL_WR
  } acc_kind_e;

  // Sort one access into the kind that drives the reservation decision.
  function automatic acc_kind_e classify(input logic vld, input logic wr, input logic ex);
    if (!vld)
      return ACC_NONE;
    else if (ex)
      return wr ? ACC_EXCL_WR : ACC_EXCL_RD;
    else
      return wr ? ACC_PLAIN_WR : ACC_PLAIN_RD;
  endfunction

endpackage

// File: rtl/excl_mon_cfg.sv
module excl_mon_cfg #(
  parameter int                 CFG_AW    = 12,
  parameter int                 CFG_DW    = 32,
  parameter logic [CFG_AW-1:0]  EN_OFFSET = 12'h018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_wr_addr,
  input  logic [CFG_DW-1:0] cfg_wr_data,
  output logic              mon_en
);

  logic hit_en_reg;

  assign hit_en_reg = cfg_wr_en && (cfg_wr_addr == EN_OFFSET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mon_en <= 1'b0;
    else if (hit_en_reg)
      mon_en <= |cfg_wr_data;
  end

endmodule

// File: rtl/excl_mon_stage.sv
module excl_mon_stage
  import excl_mon_pkg::*;
#(
  parameter int N_REQ    = 2,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3,
  parameter int ID       = 0
) (
  input  logic                     mon_en,
  input  logic                     acc_valid,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic                     acc_write,
  input  logic                     acc_excl,
  input  logic                     acc_err,
  input  logic [N_REQ-1:0]         slot_vld_i,
  input  logic [N_REQ*ADDR_W-1:0]  slot_addr_i,
  output logic [N_REQ-1:0]         slot_vld_o,
  output logic [N_REQ*ADDR_W-1:0]  slot_addr_o,
  output logic                     okay_o,
  output logic                     suppress_o,
  output logic                     evt_set_o,
  output logic                     evt_own_clr_o,
  output logic [N_REQ-1:0]         evt_kill_o
);

  localparam logic [ADDR_W-1:0] GRAN_MASK = {ADDR_W{1'b1}} << GRAN_LSB;

  function automatic logic [ADDR_W-1:0] granule_of(input logic [ADDR_W-1:0] a);
    return a & GRAN_MASK;
  endfunction

  acc_kind_e         kind;
  logic              active;
  logic [ADDR_W-1:0] gran;
  logic [ADDR_W-1:0] own_addr;
  logic              own_hit;
  logic              decision;
  logic              kill_req;

  assign kind     = classify(acc_valid, acc_write, acc_excl);
  assign active   = mon_en && (kind != ACC_NONE);
  assign gran     = granule_of(acc_addr);
  assign own_addr = slot_addr_i[ID*ADDR_W +: ADDR_W];
  assign own_hit  = slot_vld_i[ID] && (own_addr == gran);

  always_comb begin
    decision      = 1'b0;
    evt_set_o     = 1'b0;
    evt_own_clr_o = 1'b0;
    kill_req      = 1'b0;
    if (active) begin
      case (kind)
        ACC_EXCL_RD: begin
          decision  = 1'b1;
          evt_set_o = 1'b1;
        end
        ACC_EXCL_WR: begin
          decision      = own_hit;
          evt_own_clr_o = 1'b1;
          kill_req      = own_hit;
        end
        ACC_PLAIN_WR: kill_req = 1'b1;
        default: ;
      endcase
    end
  end

  // Other requesters whose stored granule equals this write's granule.
  always_comb begin
    evt_kill_o = '0;
    for (int q = 0; q < N_REQ; q++) begin
      if (q != ID && kill_req && slot_addr_i[q*ADDR_W +: ADDR_W] == gran)
        evt_kill_o[q] = 1'b1;
    end
  end

  always_comb begin
    slot_vld_o  = slot_vld_i & ~evt_kill_o;
    slot_addr_o = slot_addr_i;
    if (evt_set_o) begin
      slot_vld_o[ID]                   = 1'b1;
      slot_addr_o[ID*ADDR_W +: ADDR_W] = gran;
    end
    if (evt_own_clr_o)
      slot_vld_o[ID] = 1'b0;
  end

  always_comb begin
    if (!acc_valid)
      okay_o = !mon_en;
    else if (acc_err)
      okay_o = 1'b0;
    else if (!mon_en)
      okay_o = 1'b1;
    else
      okay_o = decision;
  end

  assign suppress_o = active && (kind == ACC_EXCL_WR) && !own_hit;

endmodule

// File: rtl/excl_mon_top.sv
module excl_mon_top #(
  parameter int N_REQ    = 2,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3,
  parameter int CFG_AW   = 12,
  parameter int CFG_DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr_en,
  input  logic [CFG_AW-1:0]       cfg_wr_addr,
  input  logic [CFG_DW-1:0]       cfg_wr_data,
  input  logic [N_REQ-1:0]        acc_valid,
  input  logic [N_REQ*ADDR_W-1:0] acc_addr,
  input  logic [N_REQ-1:0]        acc_write,
  input  logic [N_REQ-1:0]        acc_excl,
  input  logic [N_REQ-1:0]        acc_err,
  output logic [N_REQ-1:0]        excl_okay,
  output logic [N_REQ-1:0]        wr_suppress
);

  localparam int SLOT_BITS = N_REQ * ADDR_W;

  logic                   mon_en;
  logic [N_REQ-1:0]       slot_vld_q;
  logic [SLOT_BITS-1:0]   slot_addr_q;
  logic [N_REQ-1:0]       vld_chain  [0:N_REQ];
  logic [SLOT_BITS-1:0]   addr_chain [0:N_REQ];
  logic [N_REQ-1:0]       evt_set;
  logic [N_REQ-1:0]       evt_own_clr;
  logic [N_REQ*N_REQ-1:0] evt_kill;

  excl_mon_cfg #(
    .CFG_AW   (CFG_AW),
    .CFG_DW   (CFG_DW),
    .EN_OFFSET(CFG_AW'(12'h018))
  ) i_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data),
    .mon_en     (mon_en)
  );

  assign vld_chain[0]  = slot_vld_q;
  assign addr_chain[0] = slot_addr_q;

  // Lower port index is applied first; each stage sees the previous result.
  for (genvar i = 0; i < N_REQ; i++) begin : g_stage
    excl_mon_stage #(
      .N_REQ   (N_REQ),
      .ADDR_W  (ADDR_W),
      .GRAN_LSB(GRAN_LSB),
      .ID      (i)
    ) i_stage (
      .mon_en       (mon_en),
      .acc_valid    (acc_valid[i]),
      .acc_addr     (acc_addr[i*ADDR_W +: ADDR_W]),
      .acc_write    (acc_write[i]),
      .acc_excl     (acc_excl[i]),
      .acc_err      (acc_err[i]),
      .slot_vld_i   (vld_chain[i]),
      .slot_addr_i  (addr_chain[i]),
      .slot_vld_o   (vld_chain[i+1]),
      .slot_addr_o  (addr_chain[i+1]),
      .okay_o       (excl_okay[i]),
      .suppress_o   (wr_suppress[i]),
      .evt_set_o    (evt_set[i]),
      .evt_own_clr_o(evt_own_clr[i]),
      .evt_kill_o   (evt_kill[i*N_REQ +: N_REQ])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld_q  <= '0;
      slot_addr_q <= '0;
    end else begin
      slot_vld_q  <= vld_chain[N_REQ];
      slot_addr_q <= addr_chain[N_REQ];
    end
  end

endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk #(
  parameter int N_REQ = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mon_en,
  input logic [N_REQ-1:0]        acc_valid,
  input logic [N_REQ-1:0]        acc_write,
  input logic [N_REQ-1:0]        acc_excl,
  input logic [N_REQ-1:0]        acc_err,
  input logic [N_REQ-1:0]        excl_okay,
  input logic [N_REQ-1:0]        wr_suppress,
  input logic [N_REQ-1:0]        slot_vld_q,
  input logic [N_REQ-1:0]        evt_set,
  input logic [N_REQ-1:0]        evt_own_clr,
  input logic [N_REQ*N_REQ-1:0]  evt_kill
);

  for (genvar i = 0; i < N_REQ; i++) begin : g_port
    // R4
    idle_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid[i] |-> (excl_okay[i] == !mon_en));

    // R11
    err_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid[i] && acc_err[i]) |-> !excl_okay[i]);

    // R10
    suppress_only_failed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_suppress[i] |-> (mon_en && acc_valid[i] && acc_write[i] && acc_excl[i] && !excl_okay[i]));

    // R7
    own_slot_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_own_clr[i] |=> !slot_vld_q[i]);

    // R5
    set_reports_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_set[i] |-> (excl_okay[i] || acc_err[i]));
  end

  // R3
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> $stable(slot_vld_q));

  // R9
  kill_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_kill) |-> (|(acc_valid & acc_write)));

  // R5
  last_port_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set[N_REQ-1] |=> slot_vld_q[N_REQ-1]);

endmodule

bind excl_mon_top excl_mon_chk #(.N_REQ(N_REQ)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mon_en     (mon_en),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_excl   (acc_excl),
  .acc_err    (acc_err),
  .excl_okay  (excl_okay),
  .wr_suppress(wr_suppress),
  .slot_vld_q (slot_vld_q),
  .evt_set    (evt_set),
  .evt_own_clr(evt_own_clr),
  .evt_kill   (evt_kill)
);

// File: tb/test_excl_mon_top.sv
`timescale 1ns/1ps
module test_excl_mon_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [11:0] cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [1:0]  acc_valid = '0;
  logic [63:0] acc_addr = '0;
  logic [1:0]  acc_write = '0;
  logic [1:0]  acc_excl = '0;
  logic [1:0]  acc_err = '0;
  logic [1:0]  excl_okay;
  logic [1:0]  wr_suppress;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench reservation model: granule number = address / 8.
  bit          m_en = 0;
  bit          m_vld [2] = '{0, 0};
  logic [31:0] m_gran [2] = '{0, 0};

  always #5 clk = ~clk;

  excl_mon_top i_excl_mon_top (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
    .acc_excl(acc_excl), .acc_err(acc_err),
    .excl_okay(excl_okay), .wr_suppress(wr_suppress)
  );

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic acc(input int p, input bit w, input bit x, input logic [31:0] a, input bit e);
    acc_valid[p] = 1'b1;
    acc_write[p] = w;
    acc_excl[p]  = x;
    acc_err[p]   = e;
    acc_addr[p*32 +: 32] = a;
  endtask

  task automatic cfg(input logic [11:0] off, input logic [31:0] d);
    cfg_wr_en   = 1'b1;
    cfg_wr_addr = off;
    cfg_wr_data = d;
  endtask

  task automatic model(input int p, output bit ok, output bit sup);
    logic [31:0] g;
    g   = acc_addr[p*32 +: 32] / 8;
    sup = 0;
    if (!acc_valid[p]) ok = !m_en;
    else if (!m_en) ok = !acc_err[p];
    else begin
      if (acc_excl[p] && !acc_write[p]) begin
        ok = 1; m_vld[p] = 1; m_gran[p] = g;
      end else if (acc_excl[p]) begin
        ok = m_vld[p] && (m_gran[p] == g);
        m_vld[p] = 0;
        if (ok) for (int q = 0; q < 2; q++) if (q != p && m_gran[q] == g) m_vld[q] = 0;
      end else if (acc_write[p]) begin
        ok = 0;
        for (int q = 0; q < 2; q++) if (q != p && m_gran[q] == g) m_vld[q] = 0;
      end else ok = 0;
      sup = acc_excl[p] && acc_write[p] && !ok;
      ok  = ok && !acc_err[p];
    end
  endtask

  // Inputs are set after a falling edge; outputs are sampled 1 ns later.
  task automatic tick(input string tag);
    bit ok, sup;
    #1;
    for (int p = 0; p < 2; p++) begin
      model(p, ok, sup);
      chk(excl_okay[p], ok, $sformatf("%s okay port%0d", tag, p));
      chk(wr_suppress[p], sup, $sformatf("%s suppress port%0d", tag, p));
    end
    if (cfg_wr_en && cfg_wr_addr == 12'h018) m_en = (cfg_wr_data != 0);
    @(posedge clk);
    @(negedge clk);
    acc_valid = '0; acc_write = '0; acc_excl = '0; acc_err = '0;
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state: disabled, idle okay high
    #1;
    chk(excl_okay[0], 1'b1, "R1 reset okay port0");
    chk(excl_okay[1], 1'b1, "R1 reset okay port1");
    tick("R1 idle");
    // R2 wrong offset ignored, right offset enables
    cfg(12'h01C, 32'h1); tick("R2 wrong offset");
    tick("R2 still disabled");
    cfg(12'h018, 32'h4); tick("R2 enable");
    tick("R4 idle enabled");
    // R1 slots start invalid
    acc(0, 1, 1, 32'h100, 0); tick("R1 excl write without read");
    // R5 R6 same granule, different byte
    acc(0, 0, 1, 32'h100, 0); tick("R5 excl read");
    acc(0, 1, 1, 32'h107, 0); tick("R6 excl write same granule");
    // R7 reservation consumed
    acc(0, 1, 1, 32'h100, 0); tick("R7 second excl write");
    // R6 other granule
    acc(1, 0, 1, 32'h200, 0); tick("R6 read");
    acc(1, 1, 1, 32'h208, 0); tick("R6 excl write other granule");
    // R8 matching kill
    acc(0, 0, 1, 32'h300, 0); tick("R8 read p0");
    acc(1, 0, 1, 32'h304, 0); tick("R8 read p1");
    acc(1, 1, 1, 32'h300, 0); tick("R8 excl write p1");
    acc(0, 1, 1, 32'h300, 0); tick("R8 p0 lost reservation");
    // R8 non-matching kept
    acc(0, 0, 1, 32'h400, 0); tick("R8 read p0");
    acc(1, 0, 1, 32'h500, 0); tick("R8 read p1");
    acc(1, 1, 1, 32'h500, 0); tick("R8 excl write p1");
    acc(0, 1, 1, 32'h400, 0); tick("R8 p0 kept reservation");
    // R9 plain write kills others, not own
    acc(0, 0, 1, 32'h600, 0); tick("R9 read p0");
    acc(1, 1, 0, 32'h604, 0); tick("R9 plain write p1");
    acc(0, 1, 1, 32'h600, 0); tick("R9 p0 lost reservation");
    acc(1, 0, 1, 32'h700, 0); tick("R9 read p1");
    acc(1, 1, 0, 32'h700, 0); tick("R9 own plain write");
    acc(0, 0, 0, 32'h700, 0); tick("R9 plain read");
    acc(1, 1, 1, 32'h700, 0); tick("R9 own reservation kept");
    // R11 error forces low, state still updates
    acc(1, 0, 1, 32'h800, 1); tick("R11 excl read with error");
    acc(1, 1, 1, 32'h800, 0); tick("R11 reservation set despite error");
    acc(0, 1, 1, 32'h900, 1); tick("R11 failed write with error");
    // R12 same-cycle order
    acc(1, 0, 1, 32'h900, 0); tick("R12 read p1");
    acc(0, 1, 0, 32'h900, 0); acc(1, 1, 1, 32'h900, 0); tick("R12 p0 write before p1");
    acc(0, 0, 1, 32'hA00, 0); acc(1, 1, 0, 32'hA00, 0); tick("R12 p1 write after p0 read");
    acc(0, 1, 1, 32'hA00, 0); tick("R12 p0 reservation gone");
    // R3 disabled: okay high, state frozen
    acc(0, 0, 1, 32'hB00, 0); tick("R3 read p0");
    cfg(12'h018, 32'h0); tick("R3 disable");
    acc(0, 1, 1, 32'h100, 0); acc(1, 1, 0, 32'hB00, 0); tick("R3 disabled accesses");
    acc(0, 0, 1, 32'hC00, 0); acc(1, 0, 0, 32'hB00, 1); tick("R3 disabled read and error");
    tick("R4 idle disabled");
    cfg(12'h018, 32'h1); tick("R3 re-enable");
    acc(0, 1, 1, 32'hB00, 0); tick("R3 reservation survived");
    // Sweep over both ports with a small address pool
    begin
      logic [31:0] lf = 32'h1234_5678;
      logic [31:0] pool [4] = '{32'h100, 32'h104, 32'h108, 32'h10C};
      for (int n = 0; n < 4000; n++) begin
        for (int p = 0; p < 2; p++) begin
          lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
          if (lf[0]) acc(p, lf[1], lf[2], pool[lf[4:3]], lf[7:5] == 3'd0);
        end
        if (n % 97 == 50) cfg(lf[8] ? 12'h018 : 12'h014, {31'd0, lf[9] | (n < 1000)});
        tick("R12 sweep");
      end
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule